// File: doc/BRIEF.md
# Shift, Rotate and Funnel Unit

This unit moves bits for a 64-bit integer datapath. One operation goes in per accepted transfer: two operands, a shift amount, a 3-bit operation code and a word-mode flag. One 64-bit result comes out. The supported operations are logical left shift, logical right shift, arithmetic right shift, left and right rotation, and a funnel shift that joins both operands into one double-width value. In word mode only the low 32 bits of each operand are used, and the 32-bit outcome is sign-extended to 64 bits.

Operands enter through a valid/ready stream and the result leaves through another. A transfer happens on a rising clock edge when valid and ready are both high. With the default `REG_OUT = 1`, one output register sits between the two streams. The unit can take a new operation whenever that register is empty or is being drained in the same cycle, so back-pressure from the consumer reaches the producer in the same cycle. While the consumer holds `out_ready` low, a pending result stays on the outputs unchanged. The shift amount is never saturated. Bits above the operand's index width are simply ignored.

Top module: `shf_unit`

## Requirements
- R1: Op code 0 is a logical left shift. Bits that leave the top are lost and zeros enter at the bottom.
- R2: Op code 1 is a logical right shift, with zeros entering at the top. Op code 2 is an arithmetic right shift, which copies the operand's top bit into every vacated position. For example, 0xFFFFFFFFFFFFFFFE shifted by 1 gives 0x7FFFFFFFFFFFFFFF under code 1 and all ones under code 2.
- R3: Only the low 6 bits of `in_amt` are used in 64-bit mode, and only the low 5 bits in word mode. An amount of 64 in 64-bit mode, or 32 in word mode, acts as a shift of 0.
- R4: Op code 3 rotates left and op code 4 rotates right. Bits leaving one end re-enter at the other. A rotate by 0 returns `in_a`.
- R5: Op code 5 is a funnel shift. `in_a` is the upper half and `in_b` the lower half of a double-width value. That value is shifted left by the amount, and the upper half is returned. An amount of 0 returns `in_a`.
- R6: When `in_word` is 1, the operation uses `in_a[31:0]`, `in_b[31:0]` and 32-bit widths. Bits 63:32 of the result are copies of result bit 31.
- R7: Op codes 6 and 7 are reserved and give a result of zero.
- R8: The output stream behaves as follows:
  - `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
  - An accepted operation's result appears on `out_data` with `out_valid` high on the cycle after acceptance.
  - A result that has not been taken keeps its value and its valid.
  - A drained register with no new input drops `out_valid`.
- R9: While `rst_n` is low, and on the first cycle after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation code (0..5 active, 6..7 reserved) |
| in_word | input | 1 | 1 selects 32-bit word mode |
| in_a | input | 64 | Primary operand; upper half for funnel |
| in_b | input | 64 | Lower half for funnel; unused otherwise |
| in_amt | input | 8 | Shift or rotate amount, masked to index width |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer can take the result |
| out_data | output | 64 | Result word |

## Verification
Every result is due exactly one clock edge after its operation is accepted. If the consumer stalls, the result is due later, on the first edge where `out_ready` is high. The bench therefore keeps a queue of expected results, filled from a behavioural bit-by-bit model at each accepting edge. The bench samples just after the falling edge, once its own inputs have settled. It compares the head of the queue whenever `out_valid` and `out_ready` are both high. On every stalled cycle it also checks, one cycle later, that the data and valid did not move. The consumer's ready signal is toggled pseudo-randomly, so results are compared both with zero stall and after several cycles of back-pressure.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SLL  = 3'd0,
    OP_SRL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_FSH  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shf_op_e;
endpackage

// File: rtl/shf_amt_mask.sv
module shf_amt_mask #(
  parameter int AMT_W = 8,
  parameter int W     = 64,
  localparam int NW   = $clog2(W)
) (
  input  logic [AMT_W-1:0] amt,
  output logic [NW-1:0]    n
);
  // Wrap-around: keep only the index bits of the amount.
  assign n = amt[NW-1:0];
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W   = 64,
  localparam int NW = $clog2(W)
) (
  input  shf_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [NW-1:0]  n,
  output logic [W-1:0]   y
);
  logic [2*W-1:0] up_src, dn_src, up_sh, dn_sh;
  logic           take_up, take_dn;

  // Every operation is one window onto a double-width value:
  // left-type ops read the upper half after a left shift,
  // right-type ops read the lower half after a right shift.
  always_comb begin
    up_src  = {a, {W{1'b0}}};
    dn_src  = {{W{1'b0}}, a};
    take_up = 1'b0;
    take_dn = 1'b0;
    unique case (op)
      OP_SLL: begin up_src = {a, {W{1'b0}}};    take_up = 1'b1; end
      OP_ROL: begin up_src = {a, a};            take_up = 1'b1; end
      OP_FSH: begin up_src = {a, b};            take_up = 1'b1; end
      OP_SRL: begin dn_src = {{W{1'b0}}, a};    take_dn = 1'b1; end
      OP_SRA: begin dn_src = {{W{a[W-1]}}, a};  take_dn = 1'b1; end
      OP_ROR: begin dn_src = {a, a};            take_dn = 1'b1; end
      default: ;
    endcase
  end

  assign up_sh = up_src << n;
  assign dn_sh = dn_src >> n;

  always_comb begin
    if (take_up)      y = up_sh[2*W-1:W];
    else if (take_dn) y = dn_sh[W-1:0];
    else              y = '0;
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end

      AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
      AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid); // R8
      AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R8
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_word,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [AMT_W-1:0]  in_amt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NF     = $clog2(DATA_W);
  localparam int NH     = $clog2(HALF_W);

  shf_op_e             op;
  logic [NF-1:0]       n_full;
  logic [NH-1:0]       n_half;
  logic [DATA_W-1:0]   y_full;
  logic [HALF_W-1:0]   y_half;
  logic [DATA_W-1:0]   res;

  assign op = shf_op_e'(in_op);

  shf_amt_mask #(.AMT_W(AMT_W), .W(DATA_W)) u_amt_full (.amt(in_amt), .n(n_full));
  shf_amt_mask #(.AMT_W(AMT_W), .W(HALF_W)) u_amt_half (.amt(in_amt), .n(n_half));

  shf_core #(.W(DATA_W)) u_core_full (
    .op(op), .a(in_a), .b(in_b), .n(n_full), .y(y_full)
  );
  shf_core #(.W(HALF_W)) u_core_half (
    .op(op), .a(in_a[HALF_W-1:0]), .b(in_b[HALF_W-1:0]), .n(n_half), .y(y_half)
  );

  assign res = in_word ? {{HALF_W{y_half[HALF_W-1]}}, y_half} : y_full;

  shf_stage #(.W(DATA_W), .REG_OUT(REG_OUT)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op[2:1] == 2'b11 |-> res == '0); // R7
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_word |-> res[DATA_W-1:HALF_W] == {HALF_W{res[HALF_W-1]}}); // R6
  AST_FSH_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_word && in_op == OP_FSH && in_amt[NF-1:0] == '0 |-> res == in_a); // R5
  AST_ROT_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_word && (in_op == OP_ROL || in_op == OP_ROR)
      && in_amt[NF-1:0] == '0 |-> res == in_a); // R4
endmodule

// File: tb/tb_shf_unit.sv
module tb_shf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic        in_word = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [7:0]  in_amt = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int checks = 0, fails = 0, cycles = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          hold_chk = 0;
  logic [63:0] held;

  always #10 clk = ~clk; // 50 MHz

  shf_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b), .in_amt(in_amt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [2:0] op, bit word, logic [63:0] a,
                                        logic [63:0] b, logic [7:0] amt);
    int w = word ? 32 : 64;
    int n = word ? int'(amt) % 32 : int'(amt) % 64;
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) begin
      case (op)
        3'd0: r[i] = (i >= n) ? a[i-n] : 1'b0;
        3'd1: r[i] = (i + n < w) ? a[i+n] : 1'b0;
        3'd2: r[i] = (i + n < w) ? a[i+n] : a[w-1];
        3'd3: r[i] = a[(i - n + w) % w];
        3'd4: r[i] = a[(i + n) % w];
        3'd5: r[i] = (i >= n) ? a[i-n] : b[w+i-n];
        default: r[i] = 1'b0;
      endcase
    end
    if (word) for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op, bit word);
    if (word) return "R6";
    case (op)
      3'd0: return "R1";
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs just after the falling edge, once this cycle's inputs have settled.
  task automatic evaluate();
    logic [63:0] e;
    string t;
    if (hold_chk) check(out_valid && out_data == held, "R8 stall hold", out_data, held);
    hold_chk = 0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R8 unexpected output", out_data, '0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end else if (out_valid) begin
      hold_chk = 1;
      held = out_data;
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(in_op, in_word, in_a, in_b, in_amt));
      tag_q.push_back(tag_of(in_op, in_word));
    end
  endtask

  task automatic send(logic [2:0] op, bit word, logic [63:0] a, logic [63:0] b,
                      logic [7:0] amt, bit stall);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1; in_op = op; in_word = word; in_a = a; in_b = b; in_amt = amt;
      out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      #1;
      done = in_ready;
      evaluate();
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 0; out_ready = 1;
      #1;
      evaluate();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R9 in reset", {63'd0, out_valid}, '0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R9 after reset", {63'd0, out_valid}, '0);
    check(in_ready == 1, "R8 ready when empty", {63'd0, in_ready}, 64'd1);

    // R2: the sign-fill example
    send(3'd1, 0, 64'hFFFF_FFFF_FFFF_FFFE, '0, 8'd1, 0);
    send(3'd2, 0, 64'hFFFF_FFFF_FFFF_FFFE, '0, 8'd1, 0);
    // R1 and R3: masked amounts
    send(3'd0, 0, 64'h0123_4567_89AB_CDEF, '0, 8'd64, 0);
    send(3'd0, 0, 64'h0123_4567_89AB_CDEF, '0, 8'd68, 0);
    send(3'd2, 1, 64'h0000_0000_8000_0001, '0, 8'd32, 0);
    send(3'd1, 1, 64'h1234_5678_8000_0000, '0, 8'd33, 0);
    // R4 and R5: zero-amount identities and a full funnel
    send(3'd3, 0, 64'hDEAD_BEEF_0000_0001, '0, 8'd0, 0);
    send(3'd4, 0, 64'hDEAD_BEEF_0000_0001, '0, 8'd1, 0);
    send(3'd5, 0, 64'hAAAA_0000_0000_5555, 64'hF000_0000_0000_0000, 8'd0, 0);
    send(3'd5, 0, 64'hAAAA_0000_0000_5555, 64'hF000_0000_0000_0000, 8'd4, 0);
    send(3'd5, 1, 64'h0, 64'h0000_0000_8000_0000, 8'd31, 0);
    // R7: reserved codes
    send(3'd6, 0, '1, '1, 8'd5, 0);
    send(3'd7, 1, '1, '1, 8'd5, 0);
    // R6: word-mode rotate with sign extension
    send(3'd3, 1, 64'hFFFF_FFFF_4000_0000, '0, 8'd1, 0);

    for (int i = 0; i < 600; i++)
      send(3'($urandom % 8), bit'($urandom % 2), {$urandom, $urandom},
           {$urandom, $urandom}, 8'($urandom), 1);
    idle(6);
    check(exp_q.size() == 0, "R8 drained", 64'(exp_q.size()), '0);
    check(out_valid == 0, "R8 empty after drain", {63'd0, out_valid}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule